// File: doc/BRIEF.md
# Two-Stage Timebase Watchdog

This block is a watchdog timer with a register interface. A free-running timebase counter is always available for software to read. A separate interval counter runs only while the watchdog is armed. Arming takes two keys: one enable bit in each of two different control registers. Both must be set before the interval starts counting.

Expiry happens in two stages. When the first interval elapses, the block sets an expiry flag and raises an interrupt, which gives software a final chance to respond. If a second interval elapses with no restart in between, the block latches a reset-status flag and drives a reset pulse of fixed length. Software restarts the interval by writing a one to either status bit; the same write also clears that bit. A build option can lock the watchdog once it is armed, so that software can no longer disarm it.

Register writes are accepted in the cycle they are presented. Read data appears on the cycle after the read is presented. The interval length is 2^INTERVAL_LOG2 clock cycles.

Top module: `wdg_timer`

## Requirements
- R1: Registers are decoded on the full 4-bit byte address.
  - Address 0x0 is the control/status word: bit 3 is the reset-status flag, bit 2 is the expiry flag, bit 1 is arm key A, and bit 0 reads as zero.
  - Address 0x4 holds arm key B in bit 0.
  - Address 0x8 returns the timebase, zero-extended.
  - Every other address and every unused bit reads as zero.
  - Read data appears one cycle after the read is presented. On any other cycle the read data is zero.
- R2: The interval counter advances only while both keys are set. While either key is clear, it holds at zero and no expiry occurs.
- R3: Exactly 2^INTERVAL_LOG2 cycles after the edge that completes arming, the expiry flag (bit 2 of 0x0) sets.
- R4: A further full interval without a restart sets the reset-status flag (bit 3 of 0x0) and drives `wdt_reset` high for RST_PULSE_CYCLES cycles. Each later overflow while the expiry flag is still set fires the pulse again.
- R5: A write to 0x0 clears each status bit written as one and restarts the interval from zero. Status bits written as zero are left unchanged. A write with both status bits zero does not restart the interval.
- R6: If a restart write lands on the same edge as an overflow, the restart wins. No flag changes and the interval starts again.
- R7: `irq` is high exactly when the expiry flag is set and both keys are set. Disarming drops `irq` while the flag itself is kept.
- R8: The reset-status flag stays set after the pulse ends, until software writes a one to bit 3 of 0x0.
- R9: With ENABLE_ONCE=0, clearing either key disarms the watchdog. With ENABLE_ONCE=1, while both keys are set, any write that would clear a key is ignored for that key.
- R10: The timebase increments by one on every cycle after reset, whether or not the watchdog is armed. Two reads on consecutive cycles differ by one.
- R11: After reset, both keys, both flags, `irq`, `wdt_reset` and the read data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| irq | output | 1 | First-stage expiry interrupt (level) |
| wdt_reset | output | 1 | Second-stage reset pulse |

## Verification
A keepalive write and an interval overflow can fall on the same clock edge. The bench provokes this by counting cycles from a restart and issuing the next keepalive exactly 2^INTERVAL_LOG2 cycles later. It then judges the outcome from three observations: `irq` stays low, the status word reads back with both flags clear, and the reset pulse comes only one full interval later than it otherwise would. Two instances, one built with each ENABLE_ONCE setting, receive the same stimulus, so the same disarm writes show both behaviours side by side.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFS_CTRL0 = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_CTRL1 = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_TBASE = 4'h8;

    localparam int B_RST_FLAG = 3;
    localparam int B_EXP_FLAG = 2;
    localparam int B_ARM_A    = 1;
    localparam int B_ARM_B    = 0;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic keepalive;
        logic clr_exp;
        logic clr_rst;
    } kick_t;

    typedef struct packed {
        logic exp_flag;
        logic rst_flag;
    } status_t;

    function automatic logic is_wr(bus_req_t r, logic [ADDR_W-1:0] ofs);
        return r.valid && r.write && (r.addr == ofs);
    endfunction

    function automatic logic [DATA_W-1:0] ctrl0_word(status_t s, logic arm_a);
        logic [DATA_W-1:0] w;
        w = '0;
        w[B_RST_FLAG] = s.rst_flag;
        w[B_EXP_FLAG] = s.exp_flag;
        w[B_ARM_A]    = arm_a;
        return w;
    endfunction

endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int ENABLE_ONCE = 0,
    parameter int TBASE_W     = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_req_t           req,
    input  status_t            status,
    input  logic [TBASE_W-1:0] tbase,
    output logic               running,
    output kick_t              kick,
    output logic [DATA_W-1:0]  rdata
);

    logic              arm_a_q;
    logic              arm_b_q;
    logic              lock;
    logic              wr0;
    logic              wr1;
    logic [DATA_W-1:0] rd_next;

    assign running = arm_a_q && arm_b_q;
    assign wr0     = is_wr(req, OFS_CTRL0);
    assign wr1     = is_wr(req, OFS_CTRL1);

    generate
        if (ENABLE_ONCE != 0) begin : g_once
            assign lock = running;
        end else begin : g_free
            assign lock = 1'b0;
        end
    endgenerate

    always_comb begin
        kick.clr_exp   = wr0 && req.wdata[B_EXP_FLAG];
        kick.clr_rst   = wr0 && req.wdata[B_RST_FLAG];
        kick.keepalive = kick.clr_exp || kick.clr_rst;
    end

    always_comb begin
        rd_next = '0;
        if (req.valid && !req.write) begin
            case (req.addr)
                OFS_CTRL0: rd_next = ctrl0_word(status, arm_a_q);
                OFS_CTRL1: rd_next[B_ARM_B] = arm_b_q;
                OFS_TBASE: rd_next = DATA_W'(tbase);
                default:   rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_a_q <= 1'b0;
            arm_b_q <= 1'b0;
            rdata   <= '0;
        end else begin
            if (wr0 && !(lock && !req.wdata[B_ARM_A]))
                arm_a_q <= req.wdata[B_ARM_A];
            if (wr1 && !(lock && !req.wdata[B_ARM_B]))
                arm_b_q <= req.wdata[B_ARM_B];
            rdata <= rd_next;
        end
    end

endmodule

// File: rtl/wdg_interval.sv
module wdg_interval #(
    parameter int INTERVAL_LOG2 = 16,
    parameter int TBASE_W       = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     running,
    input  logic                     restart,
    output logic                     overflow,
    output logic [INTERVAL_LOG2-1:0] count,
    output logic [TBASE_W-1:0]       tbase
);

    localparam logic [INTERVAL_LOG2-1:0] CNT_LAST = '1;

    assign overflow = running && !restart && (count == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            tbase <= '0;
            count <= '0;
        end else begin
            tbase <= tbase + 1'b1;
            if (!running || restart)
                count <= '0;
            else
                count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/wdg_expiry.sv
module wdg_expiry
    import wdg_pkg::*;
#(
    parameter int RST_PULSE_CYCLES = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    overflow,
    input  kick_t   kick,
    output status_t status,
    output logic    wdt_reset
);

    localparam int PW = $clog2(RST_PULSE_CYCLES + 1);

    logic [PW-1:0] pulse_q;

    assign wdt_reset = (pulse_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            status  <= '0;
            pulse_q <= '0;
        end else begin
            if (kick.clr_exp)
                status.exp_flag <= 1'b0;
            if (kick.clr_rst)
                status.rst_flag <= 1'b0;
            if (overflow) begin
                if (!status.exp_flag)
                    status.exp_flag <= 1'b1;
                else
                    status.rst_flag <= 1'b1;
            end
            if (overflow && status.exp_flag)
                pulse_q <= PW'(RST_PULSE_CYCLES);
            else if (pulse_q != '0)
                pulse_q <= pulse_q - 1'b1;
        end
    end

endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
    import wdg_pkg::*;
#(
    parameter int TBASE_W          = 32,
    parameter int INTERVAL_LOG2    = 16,
    parameter int ENABLE_ONCE      = 0,
    parameter int RST_PULSE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [3:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              wdt_reset
);

    bus_req_t                 req;
    status_t                  status;
    kick_t                    kick;
    logic                     running;
    logic                     overflow;
    logic [INTERVAL_LOG2-1:0] count;
    logic [TBASE_W-1:0]       tbase;

    assign req.valid = bus_valid;
    assign req.write = bus_write;
    assign req.addr  = bus_addr;
    assign req.wdata = bus_wdata;

    wdg_regs #(
        .ENABLE_ONCE (ENABLE_ONCE),
        .TBASE_W     (TBASE_W)
    ) regs_i (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .status  (status),
        .tbase   (tbase),
        .running (running),
        .kick    (kick),
        .rdata   (bus_rdata)
    );

    wdg_interval #(
        .INTERVAL_LOG2 (INTERVAL_LOG2),
        .TBASE_W       (TBASE_W)
    ) interval_i (
        .clk      (clk),
        .rst      (rst),
        .running  (running),
        .restart  (kick.keepalive),
        .overflow (overflow),
        .count    (count),
        .tbase    (tbase)
    );

    wdg_expiry #(
        .RST_PULSE_CYCLES (RST_PULSE_CYCLES)
    ) expiry_i (
        .clk       (clk),
        .rst       (rst),
        .overflow  (overflow),
        .kick      (kick),
        .status    (status),
        .wdt_reset (wdt_reset)
    );

    assign irq = status.exp_flag && running;

endmodule

// File: rtl/wdg_timer_chk.sv
module wdg_timer_chk #(
    parameter int INTERVAL_LOG2 = 16,
    parameter int ENABLE_ONCE   = 0
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     bus_valid,
    input logic                     bus_write,
    input logic [3:0]               bus_addr,
    input logic [31:0]              bus_wdata,
    input logic                     running,
    input logic                     restart,
    input logic [INTERVAL_LOG2-1:0] count,
    input logic                     exp_flag,
    input logic                     rst_flag,
    input logic                     irq,
    input logic                     wdt_reset
);

    // R2: a disarmed cycle leaves the interval at zero
    p_idle_clear_r2: assert property (@(posedge clk) disable iff (rst)
        $past(!running) |-> (count == '0));

    // R3: the expiry flag can only rise while armed
    p_first_stage_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(exp_flag) |-> $past(running));

    // R4: reset pulse only follows an already-set expiry flag
    p_second_stage_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(wdt_reset) |-> $past(exp_flag));

    // R5: a keepalive brings the interval back to zero
    p_restart_zero_r5: assert property (@(posedge clk) disable iff (rst)
        $past(restart) |-> (count == '0));

    // R6: a keepalive edge never raises a flag
    p_collision_r6: assert property (@(posedge clk) disable iff (rst)
        restart |=> !$rose(exp_flag) && !$rose(rst_flag));

    // R7: no interrupt while disarmed
    p_irq_gate_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> running);

    // R8: the reset-status flag only falls on a write of one to bit 3
    p_rst_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_flag) |-> $past(bus_valid && bus_write && bus_addr == 4'h0 && bus_wdata[3]));

    generate
        if (ENABLE_ONCE != 0) begin : g_once_chk
            // R9: once armed, the lock variant stays armed
            p_once_hold_r9: assert property (@(posedge clk) disable iff (rst)
                $past(running) |-> running);
        end
    endgenerate

endmodule

bind wdg_timer wdg_timer_chk #(
    .INTERVAL_LOG2 (INTERVAL_LOG2),
    .ENABLE_ONCE   (ENABLE_ONCE)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .running   (running),
    .restart   (kick.keepalive),
    .count     (count),
    .exp_flag  (status.exp_flag),
    .rst_flag  (status.rst_flag),
    .irq       (irq),
    .wdt_reset (wdt_reset)
);

// File: tb/wdg_timer_tb_top.sv
module wdg_timer_tb_top;

    localparam int NLOG  = 5;
    localparam int LAST  = (1 << NLOG) - 1;
    localparam int PULSE = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata [2];
    logic        irq [2];
    logic        wrst [2];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wdg_timer #(.TBASE_W(32), .INTERVAL_LOG2(NLOG), .ENABLE_ONCE(0), .RST_PULSE_CYCLES(PULSE)) dut_i (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata[0]),
        .irq(irq[0]), .wdt_reset(wrst[0]));

    wdg_timer #(.TBASE_W(32), .INTERVAL_LOG2(NLOG), .ENABLE_ONCE(1), .RST_PULSE_CYCLES(PULSE)) dut_once_i (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata[1]),
        .irq(irq[1]), .wdt_reset(wrst[1]));

    // behavioural reference, index 1 is the lock variant
    logic [31:0] m_tb;
    int          m_cnt [2];
    bit          m_a [2], m_b [2], m_e [2], m_r [2];
    int          m_p [2];
    logic [31:0] m_rd [2];

    always @(posedge clk) begin
        if (rst) begin
            m_tb = '0;
            for (int k = 0; k < 2; k++) begin
                m_cnt[k] = 0; m_a[k] = 0; m_b[k] = 0; m_e[k] = 0; m_r[k] = 0;
                m_p[k] = 0; m_rd[k] = '0;
            end
        end else begin
            for (int k = 0; k < 2; k++) begin
                bit run, w0, w1, ce, cr, ka, ovf, lk, old_e;
                logic [31:0] rdn;
                run = m_a[k] && m_b[k];
                rdn = '0;
                if (bus_valid && !bus_write) begin
                    if (bus_addr == 4'h0) rdn = {28'd0, m_r[k], m_e[k], m_a[k], 1'b0};
                    else if (bus_addr == 4'h4) rdn = {31'd0, m_b[k]};
                    else if (bus_addr == 4'h8) rdn = m_tb;
                end
                w0 = bus_valid && bus_write && bus_addr == 4'h0;
                w1 = bus_valid && bus_write && bus_addr == 4'h4;
                ce = w0 && bus_wdata[2];
                cr = w0 && bus_wdata[3];
                ka = ce || cr;
                ovf = run && !ka && (m_cnt[k] == LAST);
                lk = (k == 1) && run;
                old_e = m_e[k];
                m_cnt[k] = (!run || ka) ? 0 : ((m_cnt[k] + 1) & LAST);
                if (ovf && old_e) m_p[k] = PULSE;
                else if (m_p[k] > 0) m_p[k] = m_p[k] - 1;
                if (ce) m_e[k] = 0;
                if (cr) m_r[k] = 0;
                if (ovf) begin
                    if (old_e) m_r[k] = 1;
                    else m_e[k] = 1;
                end
                if (w0 && !(lk && !bus_wdata[1])) m_a[k] = bus_wdata[1];
                if (w1 && !(lk && !bus_wdata[0])) m_b[k] = bus_wdata[0];
                m_rd[k] = rdn;
            end
            m_tb = m_tb + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int k = 0; k < 2; k++) begin
                chk("R7 irq vs model", {31'd0, irq[k]}, {31'd0, m_e[k] & m_a[k] & m_b[k]});
                chk("R4 wdt_reset vs model", {31'd0, wrst[k]}, {31'd0, m_p[k] > 0});
                chk("R1 rdata vs model", rdata[k], m_rd[k]);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v0, output logic [31:0] v1);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        v0 = rdata[0]; v1 = rdata[1];
        bus_valid = 1'b0;
    endtask

    task automatic both(input string tag, input logic [31:0] a0, input logic [31:0] a1,
                        input logic [31:0] e0, input logic [31:0] e1);
        chk(tag, a0, e0);
        chk(tag, a1, e1);
    endtask

    initial begin
        logic [31:0] v0, v1, t0, t1;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R11: reset state
        both("R11 irq after reset", {31'd0, irq[0]}, {31'd0, irq[1]}, 0, 0);
        both("R11 wdt_reset after reset", {31'd0, wrst[0]}, {31'd0, wrst[1]}, 0, 0);
        rd(4'h0, v0, v1); both("R11 ctrl0 after reset", v0, v1, 0, 0);
        rd(4'h4, v0, v1); both("R11 ctrl1 after reset", v0, v1, 0, 0);

        // R1: unmapped address, R10: timebase advances
        rd(4'hC, v0, v1); both("R1 unmapped read", v0, v1, 0, 0);
        rd(4'h8, t0, v1);
        rd(4'h8, t1, v1);
        chk("R10 timebase step", t1 - t0, 1);

        // R2: one key alone does not arm
        wr(4'h0, 32'h2);
        repeat (40) @(negedge clk);
        both("R2 single key no irq", {31'd0, irq[0]}, {31'd0, irq[1]}, 0, 0);
        rd(4'h0, v0, v1); both("R2 ctrl0 key A only", v0, v1, 32'h2, 32'h2);

        // R3: first expiry exactly one interval after arming
        wr(4'h4, 32'h1);
        repeat (LAST) @(negedge clk);
        both("R3 irq before interval", {31'd0, irq[0]}, {31'd0, irq[1]}, 0, 0);
        @(negedge clk);
        both("R3 irq at interval", {31'd0, irq[0]}, {31'd0, irq[1]}, 1, 1);
        rd(4'h0, v0, v1); both("R3 expiry flag", v0, v1, 32'h6, 32'h6);

        // R5: zero in status bits leaves them, one clears and restarts
        wr(4'h0, 32'h2);
        rd(4'h0, v0, v1); both("R5 zero write keeps flag", v0, v1, 32'h6, 32'h6);
        wr(4'h0, 32'h6);
        both("R5 keepalive clears irq", {31'd0, irq[0]}, {31'd0, irq[1]}, 0, 0);

        // R6: keepalive on the overflow edge
        repeat (LAST) @(negedge clk);
        wr(4'h0, 32'h6);
        both("R6 collision irq", {31'd0, irq[0]}, {31'd0, irq[1]}, 0, 0);
        rd(4'h0, v0, v1); both("R6 collision flags", v0, v1, 32'h2, 32'h2);

        // R4: second expiry pulse timing
        repeat (2 * LAST) @(negedge clk);
        both("R4 no pulse before second expiry", {31'd0, wrst[0]}, {31'd0, wrst[1]}, 0, 0);
        @(negedge clk);
        both("R4 pulse start", {31'd0, wrst[0]}, {31'd0, wrst[1]}, 1, 1);
        repeat (PULSE - 1) @(negedge clk);
        both("R4 pulse last cycle", {31'd0, wrst[0]}, {31'd0, wrst[1]}, 1, 1);
        @(negedge clk);
        both("R4 pulse ended", {31'd0, wrst[0]}, {31'd0, wrst[1]}, 0, 0);
        rd(4'h0, v0, v1); both("R8 reset flag held", v0, v1, 32'hE, 32'hE);

        // R9 / R7: disarm attempt
        wr(4'h0, 32'h0);
        both("R7 irq drops when disarmed", {31'd0, irq[0]}, {31'd0, irq[1]}, 0, 1);
        rd(4'h0, v0, v1); both("R9 key A after clear", v0, v1, 32'hC, 32'hE);
        wr(4'h4, 32'h0);
        rd(4'h4, v0, v1); both("R9 key B after clear", v0, v1, 32'h0, 32'h1);

        // R8: write one to bit 3 clears only the reset flag
        wr(4'h0, 32'h8);
        rd(4'h0, v0, v1); both("R8 reset flag cleared", v0, v1, 32'h4, 32'h6);

        repeat (150) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule